// File: doc/BRIEF.md
# MLT-3 Line Decoder with Self-Synchronizing Descrambler

This block sits in a 100 Mb/s twisted-pair receive path after clock and data recovery. Each recovered clock cycle it can accept one ternary line level, marked by a valid strobe. It first converts the level sequence from MLT-3 to NRZ bits. A level change gives a one and an unchanged level gives a zero. It then removes the scrambling keystream to recover the serial 5B code-group stream that the far end transmitted.

The descrambler starts with no seed. While the line carries idle, the scrambled plaintext is all ones, so each received bit XOR 1 equals the transmitter's keystream bit. The block loads eleven such bits into its own shift register and then runs it freely with the polynomial x^11 + x^9 + 1. A monitor watches the descrambled stream. It declares lock after a long enough run of consecutive ones. If no such run appears within a timeout window, it drops lock and sends the descrambler back to acquisition.

Top module: `mlt3_descrambler`

## Requirements
- R1: The ternary input is coded 2'b00 = zero level, 2'b01 = positive level, 2'b11 = negative level. The code 2'b10 is decoded exactly as the zero level.
- R2: The MLT-3 stage emits 1 when the current valid level differs from the previous valid level and 0 when it is equal. The previous level is the zero level after reset. Cycles without `sym_vld` do not change the stored level.
- R3: After reset, and after any resynchronization, the first 11 valid bits are used to load the shift register. Each is loaded as received bit XOR 1. `bit_vld` stays low for those bits.
- R4: After loading, the keystream bit is state[10] XOR state[8]. The state shifts that keystream bit in. `bit_out` is the received bit XOR the keystream bit.
- R5: The descrambled bit for a symbol given at input edge n appears on `bit_out`/`bit_vld` after edge n+2, which is two cycles of latency.
- R6: `locked` rises once LOCK_RUN (default 60) consecutive valid descrambled ones have been seen. It is low after reset.
- R7: If TIMEOUT (default 512) valid descrambled bits pass without a completed run of LOCK_RUN ones, `locked` drops and the descrambler restarts acquisition (R3).
- R8: After the block has lost lock, an idle stream restores lock and correct descrambling without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 2 | Ternary line level (R1 coding) |
| sym_vld | input | 1 | Line level valid this cycle |
| bit_out | output | 1 | Descrambled 5B code-group bit |
| bit_vld | output | 1 | bit_out is valid |
| locked | output | 1 | Descrambler lock flag |

## Verification
The hardest state to reach from the ports is the recovery path. Lock must time out, the block must then acquire on non-idle data and so load a wrong keystream, and it must finally recover on idle through a second timeout. The bench reaches this state with a bench-side scrambler and MLT-3 encoder. It locks the block on idle and then sends a long data pattern whose runs of ones never reach the lock length. It then returns to a long idle stretch and checks that lock and bit-exact descrambling come back. It does this for two scrambler seeds and uses the 2'b10 zero code on alternate passes.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

    localparam int SCR_W   = 11;
    localparam int TAP_HI  = 10;
    localparam int TAP_LO  = 8;

    typedef enum logic [1:0] {
        LV_ZERO = 2'd0,
        LV_POS  = 2'd1,
        LV_NEG  = 2'd2
    } level_t;

    typedef enum logic {
        DS_LOAD = 1'b0,
        DS_RUN  = 1'b1
    } ds_mode_t;

    typedef struct packed {
        logic vld;
        logic bit_v;
    } nrz_t;

    function automatic level_t sym_to_level(input logic [1:0] s);
        case (s)
            2'b01:   return LV_POS;
            2'b11:   return LV_NEG;
            default: return LV_ZERO;
        endcase
    endfunction

    function automatic logic key_bit(input logic [SCR_W-1:0] st);
        return st[TAP_HI] ^ st[TAP_LO];
    endfunction

endpackage

// File: rtl/mlt3_line_decode.sv
module mlt3_line_decode
    import mlt3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sym_in,
    input  logic       sym_vld,
    output nrz_t       nrz
);
    level_t prev_lvl;
    level_t cur_lvl;

    always_comb cur_lvl = sym_to_level(sym_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl  <= LV_ZERO;
            nrz       <= '0;
        end else begin
            nrz.vld   <= sym_vld;
            if (sym_vld) begin
                nrz.bit_v <= (cur_lvl != prev_lvl);
                prev_lvl  <= cur_lvl;
            end
        end
    end

    // R2: a cycle without a valid level leaves the stored level alone
    a_r2_hold_level: assert property (@(posedge clk) disable iff (rst)
        !sym_vld |=> $stable(prev_lvl));

endmodule

// File: rtl/mlt3_self_sync.sv
module mlt3_self_sync
    import mlt3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  nrz_t nrz,
    input  logic resync,
    output nrz_t plain
);
    localparam int LDW = $clog2(SCR_W + 1);

    logic [SCR_W-1:0] st;
    ds_mode_t         mode;
    logic [LDW-1:0]   ld_cnt;
    logic             ks;

    always_comb ks = key_bit(st);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            mode   <= DS_LOAD;
            ld_cnt <= '0;
            plain  <= '0;
        end else if (resync) begin
            mode   <= DS_LOAD;
            ld_cnt <= '0;
            plain  <= '0;
        end else begin
            plain.vld <= nrz.vld && (mode == DS_RUN);
            if (nrz.vld) begin
                if (mode == DS_LOAD) begin
                    st <= {st[SCR_W-2:0], ~nrz.bit_v};
                    if (ld_cnt == LDW'(SCR_W - 1)) begin
                        mode   <= DS_RUN;
                        ld_cnt <= '0;
                    end else begin
                        ld_cnt <= ld_cnt + 1'b1;
                    end
                end else begin
                    st          <= {st[SCR_W-2:0], ks};
                    plain.bit_v <= nrz.bit_v ^ ks;
                end
            end
        end
    end

    // R3: nothing valid leaves while the register is being loaded
    a_r3_load_silent: assert property (@(posedge clk) disable iff (rst)
        (mode == DS_LOAD) |=> !plain.vld);

    // R7: a resync request always restarts loading
    a_r7_resync_reload: assert property (@(posedge clk) disable iff (rst)
        resync |=> (mode == DS_LOAD) && (ld_cnt == '0));

endmodule

// File: rtl/mlt3_lock_mon.sv
module mlt3_lock_mon
    import mlt3_pkg::*;
#(
    parameter int LOCK_RUN = 60,
    parameter int TIMEOUT  = 512
) (
    input  logic clk,
    input  logic rst,
    input  nrz_t plain,
    output logic locked,
    output logic resync
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam int TW = $clog2(TIMEOUT + 1);

    logic [RW-1:0] run_cnt;
    logic [TW-1:0] tmo_cnt;
    logic          run_full;

    always_comb run_full = (run_cnt == RW'(LOCK_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            tmo_cnt <= '0;
            locked  <= 1'b0;
            resync  <= 1'b0;
        end else begin
            resync <= 1'b0;
            if (resync) begin
                run_cnt <= '0;
                tmo_cnt <= '0;
            end else if (plain.vld) begin
                if (!plain.bit_v) begin
                    run_cnt <= '0;
                end else if (!run_full) begin
                    run_cnt <= run_cnt + 1'b1;
                end
                if (plain.bit_v && (run_cnt == RW'(LOCK_RUN - 1))) begin
                    locked  <= 1'b1;
                    tmo_cnt <= '0;
                end else if (run_full && plain.bit_v) begin
                    tmo_cnt <= '0;
                end else if (tmo_cnt == TW'(TIMEOUT - 1)) begin
                    locked  <= 1'b0;
                    resync  <= 1'b1;
                    tmo_cnt <= '0;
                end else begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
            end
        end
    end

    // R6: lock only rises on a valid descrambled one
    a_r6_lock_on_one: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(plain.vld && plain.bit_v));

    // R7: a timeout leaves the block unlocked
    a_r7_drop_lock: assert property (@(posedge clk) disable iff (rst)
        resync |-> !locked);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        resync |=> !resync);

endmodule

// File: rtl/mlt3_descrambler.sv
module mlt3_descrambler
    import mlt3_pkg::*;
#(
    parameter int LOCK_RUN = 60,
    parameter int TIMEOUT  = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sym_in,
    input  logic       sym_vld,
    output logic       bit_out,
    output logic       bit_vld,
    output logic       locked
);
    nrz_t nrz;
    nrz_t plain;
    logic resync;

    mlt3_line_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .sym_in (sym_in),
        .sym_vld(sym_vld),
        .nrz    (nrz)
    );

    mlt3_self_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .nrz   (nrz),
        .resync(resync),
        .plain (plain)
    );

    mlt3_lock_mon #(.LOCK_RUN(LOCK_RUN), .TIMEOUT(TIMEOUT)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .plain (plain),
        .locked(locked),
        .resync(resync)
    );

    assign bit_out = plain.bit_v;
    assign bit_vld = plain.vld;

    // R5: a valid output needs a valid symbol two cycles earlier
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        bit_vld |-> $past(sym_vld, 2));

endmodule

// File: tb/mlt3_descrambler_bench.sv
module mlt3_descrambler_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sym_in;
    logic       sym_vld;
    logic       bit_out, bit_vld, locked;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [10:0] s_tx;
    int          enc_idx;
    logic [1:0]  zero_code;
    logic        p_h0, p_h1;
    logic        v_h0, v_h1;

    always #2.5 clk = ~clk;

    mlt3_descrambler u_mlt3_descrambler (
        .clk(clk), .rst(rst), .sym_in(sym_in), .sym_vld(sym_vld),
        .bit_out(bit_out), .bit_vld(bit_vld), .locked(locked)
    );

    task automatic check(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [1:0] level_code(input int idx);
        case (idx)
            1: return 2'b01;
            3: return 2'b11;
            default: return zero_code;
        endcase
    endfunction

    // drive one plaintext bit; optionally check output of the bit two drives ago
    task automatic send(input logic p, input bit chk);
        logic k;
        @(negedge clk);
        if (chk && v_h1) begin
            check("R4/R5 data", bit_out, p_h1);
            check("R5 valid", bit_vld, 1'b1);
        end
        k    = s_tx[10] ^ s_tx[8];
        s_tx = {s_tx[9:0], k};
        if (p ^ k) enc_idx = (enc_idx + 1) % 4;
        sym_in  = level_code(enc_idx);
        sym_vld = 1'b1;
        p_h1 = p_h0; v_h1 = v_h0;
        p_h0 = p;    v_h0 = 1'b1;
    endtask

    task automatic idle(input int n, input bit chk);
        for (int i = 0; i < n; i++) send(1'b1, chk);
    endtask

    task automatic data(input int n, input bit chk);
        for (int i = 0; i < n; i++) send((i % 7) != 0 && (i % 11) != 3, chk);
    endtask

    task automatic run_pass(input logic [10:0] seed, input logic [1:0] zc);
        @(negedge clk);
        rst = 1'b1; sym_vld = 1'b0; sym_in = 2'b00;
        s_tx = seed; enc_idx = 0; zero_code = zc;
        v_h0 = 1'b0; v_h1 = 1'b0; p_h0 = 1'b0; p_h1 = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R6 reset lock", locked, 1'b0);
        check("R3 reset valid", bit_vld, 1'b0);
        rst = 1'b0;
        idle(11, 1'b0);
        check("R3 load silent", bit_vld, 1'b0);
        idle(40, 1'b0);
        check("R6 not yet locked", locked, 1'b0);
        idle(60, 1'b0);
        check("R6 locked", locked, 1'b1);
        idle(20, 1'b1);
        data(400, 1'b1);
        check("R7 still locked", locked, 1'b1);
        data(300, 1'b0);
        check("R7 timeout drop", locked, 1'b0);
        idle(2000, 1'b0);
        check("R8 relock", locked, 1'b1);
        data(200, 1'b1);
        // R2: a gap in sym_vld must not disturb the decode
        @(negedge clk); sym_vld = 1'b0; sym_in = 2'b11;
        @(negedge clk); sym_in = 2'b01;
        v_h1 = v_h0; v_h0 = 1'b0;
        @(negedge clk);
        v_h1 = 1'b0;
        check("R2 gap no valid", bit_vld, 1'b0);
        data(100, 1'b1);
    endtask

    initial begin
        rst = 1'b1; sym_vld = 1'b0; sym_in = 2'b00;
        s_tx = 11'h1; enc_idx = 0; zero_code = 2'b00;
        p_h0 = 0; p_h1 = 0; v_h0 = 0; v_h1 = 0;
        run_pass(11'h5A3, 2'b00);
        run_pass(11'h0F1, 2'b10);   // R1: alternate zero code
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule